// File: doc/BRIEF.md
# Systolic Sliding-Window Gradient-Histogram Classifier

This block scores a stream of per-pixel gradient features against a linear classifier. The classifier covers a detection window five cells wide and five cells tall. Each incoming pixel carries an orientation bin and a gradient magnitude. The block does not store features and then compute a dot product. Instead, a chain of 25 multiply-accumulate elements scores every pixel at the same time against all 25 windows that overlap the current cell. Element `k` holds the signed per-bin weights for window position `k`. For every valid pixel it adds magnitude times weight to its running partial score.

When the pixel stream crosses a cell boundary, the upstream cell logic pulses a shift strobe. On that strobe, each partial score moves one element along the chain, and the value that falls off the end is a complete window score. That score is registered on the output and compared against a signed programmable threshold, which produces a one-cycle detect pulse. The weights are elaboration-time parameters, produced by offline training.

Top module: `hog_window_classifier`

## Requirements
- R1: A synchronous active-high reset clears every element's partial score and drives `score` to 0 and `detect` to 0. After reset, 25 shifts with no pixels produce 25 scores of exactly 0.
- R2: With the default parameters, the weight of element k (0..24) for bin b (0..8) is ((37·k + 23·b + 11) mod 255) − 127, a signed 8-bit value in −127..+127.
- R3: A cycle with `pix_valid`=1 and `pix_bin` in 0..8 adds `pix_mag` (16-bit unsigned) × weight(k, `pix_bin`) to every element k. Accumulation is 32-bit two's complement and wraps on overflow.
- R4: A pixel has no effect on any element when `pix_valid`=0, or when `pix_bin` is 9..15.
- R5: On a cycle with `cell_shift`=1, element k takes the old value of element k−1 and element 0 takes zero. `score` takes the old value of element 24 in the following cycle and holds it until the next shift.
- R6: When `cell_shift` and a valid pixel arrive in the same cycle, the pixel's product is added after the move. Element k ends with the old value of element k−1 plus its own product, and element 0 ends with its own product alone.
- R7: `detect` is 1 in the cycle after a shift exactly when the score leaving the chain is strictly greater than `threshold`, both compared as signed 32-bit values. A score equal to the threshold gives 0.
- R8: `detect` is 0 in every cycle that does not directly follow a shift strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | Pixel feature present this cycle |
| pix_bin | input | 4 | Orientation bin, 0..8 used |
| pix_mag | input | 16 | Unsigned gradient magnitude |
| cell_shift | input | 1 | Cell-advance strobe |
| threshold | input | 32 | Signed detection threshold |
| score | output | 32 | Signed score of the last completed window |
| detect | output | 1 | One-cycle flag, score above threshold |

## Verification
The bench sets the threshold to exactly the score about to leave the chain, and then to one below it. A design that compared with greater-or-equal, or compared unsigned, would raise `detect` on the equal case or miss it on negative scores. It drives pixels together with the shift strobe. A design that added the product before moving, or gave it to the wrong element, would send wrong totals 25 cells later. It also feeds invalid pixels and bins 9..15 carrying large magnitudes. A design that indexed past the weight table, or ignored `pix_valid`, would corrupt later scores. Full-scale magnitudes against negative weights check sign extension of the products. A mid-stream reset followed by empty cells checks that no stale partial score leaks out.

// File: rtl/hog_win_pkg.sv
package hog_win_pkg;

    localparam int WIN_COLS = 5;
    localparam int WIN_ROWS = 5;
    localparam int NPE      = WIN_COLS * WIN_ROWS;
    localparam int NUM_BINS = 9;
    localparam int BIN_W    = $clog2(NUM_BINS);
    localparam int MAG_W    = 16;
    localparam int WGT_W    = 8;
    localparam int ACC_W    = 32;
    localparam int PROD_W   = MAG_W + WGT_W + 1;
    localparam int ROW_W    = NUM_BINS * WGT_W;
    localparam int TBL_W    = NPE * ROW_W;

    typedef logic signed [ACC_W-1:0] acc_t;
    typedef logic signed [WGT_W-1:0] wgt_t;

    typedef struct packed {
        logic             vld;
        logic [BIN_W-1:0] bin;
        logic [MAG_W-1:0] mag;
    } pixel_t;

    // Placeholder weight set for elaboration; real sets come from training.
    function automatic logic [TBL_W-1:0] default_weights();
        logic [TBL_W-1:0] t;
        t = '0;
        for (int k = 0; k < NPE; k++) begin
            for (int b = 0; b < NUM_BINS; b++) begin
                int v;
                v = ((37 * k + 23 * b + 11) % 255) - 127;
                t[(k*NUM_BINS + b)*WGT_W +: WGT_W] = WGT_W'(v);
            end
        end
        return t;
    endfunction

    function automatic acc_t widen_prod(input logic signed [PROD_W-1:0] p);
        return {{(ACC_W-PROD_W){p[PROD_W-1]}}, p};
    endfunction

endpackage

// File: rtl/hog_weight_rom.sv
module hog_weight_rom
    import hog_win_pkg::*;
#(
    parameter logic [ROW_W-1:0] ROW = '0
) (
    input  logic [BIN_W-1:0] bin,
    output wgt_t             wgt,
    output logic             hit
);
    always_comb begin
        wgt = '0;
        hit = 1'b0;
        for (int b = 0; b < NUM_BINS; b++) begin
            if (bin == BIN_W'(b)) begin
                wgt = ROW[b*WGT_W +: WGT_W];
                hit = 1'b1;
            end
        end
    end
endmodule

// File: rtl/hog_pe.sv
module hog_pe
    import hog_win_pkg::*;
#(
    parameter logic [ROW_W-1:0] ROW = '0
) (
    input  logic   clk,
    input  logic   rst,
    input  pixel_t pix,
    input  logic   shift,
    input  acc_t   acc_in,
    output acc_t   acc_out
);
    wgt_t                     wgt;
    logic                     hit;
    logic signed [PROD_W-1:0] prod;
    acc_t                     base;
    acc_t                     addend;
    acc_t                     acc_q;
    logic                     use_pix;

    hog_weight_rom #(.ROW(ROW)) rom_i (
        .bin (pix.bin),
        .wgt (wgt),
        .hit (hit)
    );

    always_comb begin
        use_pix = pix.vld & hit;
        prod    = $signed({1'b0, pix.mag}) * wgt;
        addend  = use_pix ? widen_prod(prod) : '0;
        base    = shift ? acc_in : acc_q;
    end

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= base + addend;
    end

    assign acc_out = acc_q;

    a_r1_reset_clears: assert property (@(posedge clk) rst |=> acc_q == '0);
    a_r5_shift_takes_prev: assert property (@(posedge clk) disable iff (rst)
        (shift && !pix.vld) |=> acc_q == $past(acc_in));
    a_r4_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!shift && !pix.vld) |=> $stable(acc_q));
endmodule

// File: rtl/hog_score_cmp.sv
module hog_score_cmp
    import hog_win_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic shift,
    input  acc_t tail,
    input  acc_t thr,
    output acc_t score,
    output logic detect
);
    acc_t score_q;
    logic det_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            score_q <= '0;
            det_q   <= 1'b0;
        end else begin
            det_q <= shift && (tail > thr);
            if (shift) score_q <= tail;
        end
    end

    assign score  = score_q;
    assign detect = det_q;

    a_r8_detect_needs_shift: assert property (@(posedge clk) disable iff (rst)
        detect |-> $past(shift));
    a_r7_detect_strict: assert property (@(posedge clk) disable iff (rst)
        detect |-> ($past(tail) > $past(thr)));
    a_r5_score_holds: assert property (@(posedge clk) disable iff (rst)
        !shift |=> $stable(score_q));
endmodule

// File: rtl/hog_window_classifier.sv
module hog_window_classifier
    import hog_win_pkg::*;
#(
    parameter logic [TBL_W-1:0] WEIGHTS = default_weights()
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    pix_valid,
    input  logic [BIN_W-1:0]        pix_bin,
    input  logic [MAG_W-1:0]        pix_mag,
    input  logic                    cell_shift,
    input  logic signed [ACC_W-1:0] threshold,
    output logic signed [ACC_W-1:0] score,
    output logic                    detect
);
    pixel_t pix;
    acc_t   chain [NPE+1];

    assign pix      = '{vld: pix_valid, bin: pix_bin, mag: pix_mag};
    assign chain[0] = '0;

    for (genvar k = 0; k < NPE; k++) begin : g_pe
        hog_pe #(.ROW(WEIGHTS[k*ROW_W +: ROW_W])) pe_i (
            .clk     (clk),
            .rst     (rst),
            .pix     (pix),
            .shift   (cell_shift),
            .acc_in  (chain[k]),
            .acc_out (chain[k+1])
        );
    end

    hog_score_cmp cmp_i (
        .clk    (clk),
        .rst    (rst),
        .shift  (cell_shift),
        .tail   (chain[NPE]),
        .thr    (threshold),
        .score  (score),
        .detect (detect)
    );
endmodule

// File: tb/hog_window_classifier_tb.sv
module hog_window_classifier_tb_top;
    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              pix_valid = 1'b0;
    logic [3:0]        pix_bin = '0;
    logic [15:0]       pix_mag = '0;
    logic              cell_shift = 1'b0;
    logic signed [31:0] threshold = '0;
    logic signed [31:0] score;
    logic              detect;

    always #5 clk = ~clk;

    hog_window_classifier dut_i (
        .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_bin(pix_bin),
        .pix_mag(pix_mag), .cell_shift(cell_shift), .threshold(threshold),
        .score(score), .detect(detect)
    );

    typedef struct { logic signed [31:0] s; logic d; } exp_t;
    exp_t q[$];
    logic signed [31:0] mdl [25];
    int n_chk = 0, n_bad = 0;
    logic sh_d = 1'b0;
    logic finished = 1'b0;
    logic [31:0] seed = 32'h1234_5678;

    function automatic int wt(int k, int b);
        return ((37 * k + 23 * b + 11) % 255) - 127;   // R2
    endfunction

    function automatic logic [31:0] rnd();
        seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
        return seed;
    endfunction

    task automatic check(string req, logic signed [31:0] act, logic signed [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic step(logic v, logic [3:0] b, logic [15:0] m, logic s);
        @(negedge clk);
        pix_valid = v; pix_bin = b; pix_mag = m; cell_shift = s;
        if (s) begin
            q.push_back('{mdl[24], (mdl[24] > threshold)});
            for (int k = 24; k > 0; k--) mdl[k] = mdl[k-1];
            mdl[0] = '0;
        end
        if (v && b < 9)
            for (int k = 0; k < 25; k++) mdl[k] = mdl[k] + 32'(int'(m) * wt(k, int'(b)));
    endtask

    task automatic random_cell(int npix, logic s_with_last);
        for (int i = 0; i < npix; i++) begin
            logic [31:0] r;
            r = rnd();
            step(1'b1, 4'(r[7:0] % 9), r[31:16], (i == npix - 1) && s_with_last);
        end
        if (!s_with_last) step(1'b0, '0, '0, 1'b1);
    endtask

    always @(posedge clk) sh_d <= rst ? 1'b0 : cell_shift;

    always @(negedge clk) begin
        if (!rst) begin
            if (sh_d) begin
                if (q.size() == 0) begin
                    n_chk++; n_bad++;
                    $display("FAIL R5: actual unexpected score %0d expected none", score);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check("R3/R5 score", score, e.s);
                    check("R7 detect", 32'(detect), 32'(e.d));
                end
            end else begin
                check("R8 detect idle", 32'(detect), 0);
            end
        end
    end

    initial begin
        for (int k = 0; k < 25; k++) mdl[k] = '0;
        threshold = 32'sd1000000;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset score", score, 0);
        check("R1 reset detect", 32'(detect), 0);

        // R2 R3 R5: ordinary stream, shift on its own cycle
        for (int c = 0; c < 30; c++) random_cell(1 + c % 5, 1'b0);

        // R4: invalid pixels and out-of-range bins with large magnitudes
        for (int c = 0; c < 6; c++) begin
            step(1'b0, 4'd3, 16'hFFFF, 1'b0);
            step(1'b1, 4'(9 + c), 16'hFFFF, 1'b0);
            step(1'b1, 4'd15, 16'hABCD, 1'b0);
            step(1'b1, 4'(c), 16'd100, 1'b0);
            step(1'b0, 4'd0, 16'h7777, 1'b1);
        end

        // R6: pixel together with the shift strobe
        for (int c = 0; c < 28; c++) random_cell(2 + c % 3, 1'b1);

        // R3: full-scale magnitudes, negative thresholds
        threshold = -32'sd5000000;
        for (int c = 0; c < 27; c++) begin
            for (int b = 0; b < 9; b++) step(1'b1, 4'(b), 16'hFFFF, 1'b0);
            step(1'b1, 4'((c * 4) % 9), 16'hFFFF, 1'b1);
        end

        // R7: threshold boundary, equal then one below
        for (int c = 0; c < 10; c++) begin
            random_cell(3, 1'b0);
            @(negedge clk);
            pix_valid = 1'b0; cell_shift = 1'b0;
            threshold = (c % 2 == 0) ? mdl[24] : mdl[24] - 1;
            step(1'b0, '0, '0, 1'b1);
        end

        // R1: reset mid-stream clears partial scores
        step(1'b0, '0, '0, 1'b0);
        @(negedge clk);
        rst = 1'b1; cell_shift = 1'b0;
        q.delete();
        for (int k = 0; k < 25; k++) mdl[k] = '0;
        @(negedge clk);
        rst = 1'b0;
        threshold = -32'sd1;
        for (int c = 0; c < 25; c++) step(1'b0, '0, '0, 1'b1);
        step(1'b0, '0, '0, 1'b0);
        step(1'b0, '0, '0, 1'b0);
        step(1'b0, '0, '0, 1'b0);
        check("R5 queue drained", 32'(q.size()), 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule